// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block collects up to eight interrupt request lines, ranks them with level 0 as the most urgent, and raises a single interrupt output whenever a request is allowed to interrupt the processor. It keeps three state vectors: a pending-request vector, an in-service vector and a mask vector. Bit i of each vector always belongs to level i.

A processor reaches the block through an 8-bit register port with chip select, a one-bit address, and read and write strobes. At address 1 the port reads and writes the mask. At address 0, writes carry command words and reads return status. A command word can do three things. It can retire an in-service level, either the most urgent one or a named one. It can pick which status vector later reads return. It can turn special mask mode on or off, under an enable bit. A command word can also arm a one-shot poll. The next read then acts as an acknowledge and returns the level that won.

Top module: `prio_irq_ctl`

## Requirements
- R1: An active-high synchronous reset clears the pending, in-service and mask vectors. After reset, status reads at address 0 return the pending vector, special mask mode is off, poll is disarmed and `irq_out` is low.
- R2: One clock edge after `irq_req` changes, the pending vector (bit i = level i) equals the high request lines not set in the mask. A write to address 1 loads the mask, and a read at address 1 returns it.
- R3: A command-word write at address 0 is decoded by bits [1:0]. 10 makes later status reads return the pending vector, and 11 makes them return the in-service vector. 00 or 01 keep the current choice. The choice holds for any number of reads.
- R4: Setting bit 2 of a command word arms poll, and the very next read disarms it. That read returns bit 7 = 1 and the winning level in bits [2:0] when a request is eligible. Otherwise it returns 0x00 and changes no state.
- R5: A poll read that finds a winner sets that level's in-service bit.
- R6: In normal mask mode, a pending level is eligible only when its index is lower than every set in-service bit. `irq_out` is high exactly while some level is eligible.
- R7: In a command word with bit 5 = 1, bit 6 = 1 enters special mask mode and bit 6 = 0 leaves it. With bit 5 = 0, the mode is unchanged. In special mask mode, any pending level whose in-service bit is clear is eligible.
- R8: A write at address 0 counts as a command word only when bits [4:3] = 01 and bit 7 = 0. A word with bits [4:3] = 01 and bit 7 = 1 has no effect.
- R9: A write at address 0 with bits [4:3] = 00, bit 5 = 1 and bit 6 = 0 clears the lowest-index set in-service bit. Bits [2:0] of this word are ignored.
- R10: A write at address 0 with bits [4:3] = 00, bit 5 = 1 and bit 6 = 1 clears only the in-service bit named by bits [2:0].
- R11: When several levels are eligible together, a poll returns the lowest index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | 8 | Level-sensitive request lines, bit i = level i |
| cs | input | 1 | Chip select |
| addr | input | 1 | 0 = command/status, 1 = mask |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the same cycle as the read strobe |
| irq_out | output | 1 | High while some level is eligible |

## Verification
Read data is combinational: it is valid in the cycle that `cs` and `rd` are high. The side effects of a read or write take hold at the next rising edge. A request change reaches the pending vector, and from there `irq_out`, one edge later. Every bench operation drives its inputs on a falling edge and samples `rdata` shortly after that. It checks `irq_out` only after at least one rising edge has passed since the last stimulus. No expected value is ever sampled in the same cycle as the edge that produces it.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   localparam int LVL_W = 3;

   typedef enum logic [1:0] {
      CW_NONE,
      CW_EOI_ANY,
      CW_EOI_LVL,
      CW_CTRL
   } cw_kind_e;

   typedef struct packed {
      cw_kind_e           kind;
      logic [LVL_W-1:0]   lvl;
      logic               sel_wr;
      logic               sel_isr;
      logic               smm_wr;
      logic               smm_val;
      logic               poll;
   } cw_t;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  vec,
   output logic [N-1:0]  onehot,
   output logic [N-1:0]  upto,
   output logic [IW-1:0] idx
);
   logic [N-1:0] below;

   generate
      if (N < 2 || N > (1 << IW)) begin : g_bad_width
         $error("irq_prio_enc: N out of range for IW");
      end
      for (genvar i = 0; i < N; i++) begin : g_chain
         if (i == 0) begin : g_first
            assign below[i] = 1'b0;
         end else begin : g_rest
            assign below[i] = below[i-1] | vec[i-1];
         end
      end
   endgenerate

   assign onehot = vec & ~below;
   assign upto   = below | vec;

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (onehot[i]) idx = idx | IW'(i);
      end
   end
endmodule

// File: rtl/prio_irq_cwdec.sv
module prio_irq_cwdec
   import prio_irq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              wr_cmd,
   input  logic [DATA_W-1:0] wdata,
   output cw_t               cw
);
   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("prio_irq_cwdec: DATA_W must be 8");
      end
   endgenerate

   always_comb begin
      cw      = '0;
      cw.kind = CW_NONE;
      if (wr_cmd) begin
         if (wdata[4:3] == 2'b01 && !wdata[7]) begin
            cw.kind    = CW_CTRL;
            cw.sel_wr  = wdata[1];
            cw.sel_isr = wdata[0];
            cw.smm_wr  = wdata[5];
            cw.smm_val = wdata[6];
            cw.poll    = wdata[2];
         end else if (wdata[4:3] == 2'b00 && wdata[5]) begin
            cw.kind = wdata[6] ? CW_EOI_LVL : CW_EOI_ANY;
            cw.lvl  = wdata[LVL_W-1:0];
         end
      end
   end
endmodule

// File: rtl/prio_irq_ctl.sv
module prio_irq_ctl
   import prio_irq_pkg::*;
#(
   parameter int NUM_LEVELS = 8,
   parameter int DATA_W     = 8
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [NUM_LEVELS-1:0] irq_req,
   input  logic                  cs,
   input  logic                  addr,
   input  logic                  rd,
   input  logic                  wr,
   input  logic [DATA_W-1:0]     wdata,
   output logic [DATA_W-1:0]     rdata,
   output logic                  irq_out
);
   localparam int N = NUM_LEVELS;

   generate
      if (N < 2 || N > (1 << LVL_W)) begin : g_bad_levels
         $error("prio_irq_ctl: NUM_LEVELS must be 2..8");
      end
      if (DATA_W < N) begin : g_bad_dw
         $error("prio_irq_ctl: DATA_W narrower than NUM_LEVELS");
      end
   endgenerate

   logic [N-1:0] irr, isr, mask;
   logic         sel_isr, smm, poll_armed;

   logic wr_cmd, wr_mask, rd_any, poll_ack;
   assign wr_cmd   = cs & wr & ~addr;
   assign wr_mask  = cs & wr & addr;
   assign rd_any   = cs & rd & ~wr;
   assign poll_ack = rd_any & poll_armed;

   cw_t cw;
   prio_irq_cwdec #(.DATA_W(DATA_W)) u_dec (
      .wr_cmd (wr_cmd),
      .wdata  (wdata),
      .cw     (cw)
   );

   logic [N-1:0]     isr_oh, isr_upto;
   logic [LVL_W-1:0] isr_top_idx;
   irq_prio_enc #(.N(N), .IW(LVL_W)) u_isr_enc (
      .vec    (isr),
      .onehot (isr_oh),
      .upto   (isr_upto),
      .idx    (isr_top_idx)
   );

   logic [N-1:0] allowed, eligible;
   assign allowed  = smm ? ~isr : ~isr_upto;
   assign eligible = irr & allowed;

   logic [N-1:0]     elig_oh, elig_upto;
   logic [LVL_W-1:0] elig_idx;
   irq_prio_enc #(.N(N), .IW(LVL_W)) u_elig_enc (
      .vec    (eligible),
      .onehot (elig_oh),
      .upto   (elig_upto),
      .idx    (elig_idx)
   );

   assign irq_out = elig_upto[N-1];

   logic [DATA_W-1:0] poll_word;
   always_comb begin
      poll_word = '0;
      if (irq_out) begin
         poll_word[DATA_W-1]  = 1'b1;
         poll_word[LVL_W-1:0] = elig_idx;
      end
   end

   always_comb begin
      if (!rd_any)         rdata = '0;
      else if (poll_armed) rdata = poll_word;
      else if (addr)       rdata = DATA_W'(mask);
      else if (sel_isr)    rdata = DATA_W'(isr);
      else                 rdata = DATA_W'(irr);
   end

   logic [N-1:0] lvl_oh, isr_nxt, ack_oh;
   assign lvl_oh = N'(1) << cw.lvl;
   assign ack_oh = (poll_ack && irq_out) ? elig_oh : '0;

   always_comb begin
      isr_nxt = isr | ack_oh;
      case (cw.kind)
         CW_EOI_ANY: isr_nxt = isr_nxt & ~isr_oh;
         CW_EOI_LVL: isr_nxt = isr_nxt & ~lvl_oh;
         default:    ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         irr        <= '0;
         isr        <= '0;
         mask       <= '0;
         sel_isr    <= 1'b0;
         smm        <= 1'b0;
         poll_armed <= 1'b0;
      end else begin
         irr <= irq_req & ~mask & ~ack_oh;
         isr <= isr_nxt;
         if (wr_mask) mask <= wdata[N-1:0];
         if (cw.kind == CW_CTRL) begin
            if (cw.sel_wr) sel_isr <= cw.sel_isr;
            if (cw.smm_wr) smm     <= cw.smm_val;
            poll_armed <= cw.poll;
         end else if (rd_any) begin
            poll_armed <= 1'b0;
         end
      end
   end

   // R2: pending vector never holds a level masked on the prior cycle
   p_irr_masked_r2: assert property (@(posedge clk) disable iff (rst)
      (irr & $past(mask)) == '0);

   p_sel_kept_r3: assert property (@(posedge clk) disable iff (rst)
      (cw.kind == CW_CTRL && !cw.sel_wr) |=> $stable(sel_isr));

   p_poll_once_r4: assert property (@(posedge clk) disable iff (rst)
      rd_any |=> !poll_armed);

   p_ack_sets_isr_r5: assert property (@(posedge clk) disable iff (rst)
      (poll_ack && irq_out) |=> ((isr & $past(elig_oh)) == $past(elig_oh)));

   p_smm_kept_r7: assert property (@(posedge clk) disable iff (rst)
      (cw.kind == CW_CTRL && !cw.smm_wr) |=> $stable(smm));

   p_eoi_any_r9: assert property (@(posedge clk) disable iff (rst)
      (cw.kind == CW_EOI_ANY && isr_upto[N-1]) |=> !isr[$past(isr_top_idx)]);
endmodule

// File: tb/sim_prio_irq_ctl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctl;
   logic       clk = 1'b0;
   logic       rst;
   logic [7:0] irq_req;
   logic       cs, addr, rd, wr;
   logic [7:0] wdata;
   logic [7:0] rdata;
   logic       irq_out;
   int         errors = 0;
   int         checks = 0;

   always #2.5 clk = ~clk;

   prio_irq_ctl u0 (
      .clk(clk), .rst(rst), .irq_req(irq_req), .cs(cs), .addr(addr),
      .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
   );

   // {mask, request, expected pending}
   localparam logic [23:0] VEC [6] = '{
      24'h00_A5_A5, 24'h0F_FF_F0, 24'hFF_FF_00,
      24'h81_81_00, 24'h3C_C3_C3, 24'h55_AA_AA
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic a, input logic [7:0] d);
      @(negedge clk);
      cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      cs = 1'b0; wr = 1'b0;
   endtask

   task automatic rd_reg(input logic a, output logic [7:0] d);
      @(negedge clk);
      cs = 1'b1; rd = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      cs = 1'b0; rd = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] d;
      rst = 1'b1; irq_req = '0; cs = 0; addr = 0; rd = 0; wr = 0; wdata = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1 reset state
      chk("R1 irq_out after reset", {7'b0, irq_out}, 8'h00);
      rd_reg(1'b0, d); chk("R1 status after reset", d, 8'h00);
      rd_reg(1'b1, d); chk("R1 mask after reset", d, 8'h00);

      // R2 table: mask, request, expected pending (default select is pending, R1)
      for (int k = 0; k < 6; k++) begin
         wr_reg(1'b1, VEC[k][23:16]);
         irq_req = VEC[k][15:8];
         rd_reg(1'b0, d); chk("R2 pending vector", d, VEC[k][7:0]);
         rd_reg(1'b1, d); chk("R2 mask readback", d, VEC[k][23:16]);
      end
      wr_reg(1'b1, 8'h00);
      irq_req = 8'h00;

      // R4 poll with nothing eligible
      tick();
      wr_reg(1'b0, 8'h0C);
      rd_reg(1'b0, d); chk("R4 empty poll", d, 8'h00);
      rd_reg(1'b0, d); chk("R4 poll disarmed", d, 8'h00);

      // R4/R5 poll acknowledge
      irq_req = 8'h28;
      tick();
      chk("R6 irq with idle isr", {7'b0, irq_out}, 8'h01);
      wr_reg(1'b0, 8'h0C);
      rd_reg(1'b0, d); chk("R4 poll reply level3", d, 8'h83);
      wr_reg(1'b0, 8'h0B);
      rd_reg(1'b0, d); chk("R5 isr set by ack", d, 8'h08);
      rd_reg(1'b0, d); chk("R3 repeat read isr", d, 8'h08);
      wr_reg(1'b0, 8'h08);
      rd_reg(1'b0, d); chk("R3 select kept 00", d, 8'h08);
      wr_reg(1'b0, 8'h09);
      rd_reg(1'b0, d); chk("R3 select kept 01", d, 8'h08);

      // R6 normal mode nesting
      chk("R6 lower level blocked", {7'b0, irq_out}, 8'h00);
      irq_req = 8'h2C;
      tick();
      chk("R6 higher level passes", {7'b0, irq_out}, 8'h01);
      wr_reg(1'b0, 8'h0C);
      rd_reg(1'b0, d); chk("R4 poll reply level2", d, 8'h82);
      tick();
      chk("R6 all blocked by level2", {7'b0, irq_out}, 8'h00);

      // R9 non-specific EOI
      wr_reg(1'b0, 8'h20);
      rd_reg(1'b0, d); chk("R9 eoi clears level2", d, 8'h08);
      chk("R9 level2 eligible again", {7'b0, irq_out}, 8'h01);

      // R10 specific EOI
      wr_reg(1'b0, 8'h0C);
      rd_reg(1'b0, d); chk("R4 poll reply level2 again", d, 8'h82);
      wr_reg(1'b0, 8'h63);
      rd_reg(1'b0, d); chk("R10 specific clears level3", d, 8'h04);
      wr_reg(1'b0, 8'h27);
      rd_reg(1'b0, d); chk("R9 level field ignored", d, 8'h00);

      // R7 special mask mode
      irq_req = 8'h28;
      wr_reg(1'b0, 8'h0C);
      rd_reg(1'b0, d); chk("R4 poll reply level3 again", d, 8'h83);
      tick();
      chk("R6 level5 blocked", {7'b0, irq_out}, 8'h00);
      wr_reg(1'b0, 8'h68);
      chk("R7 smm lets level5", {7'b0, irq_out}, 8'h01);
      wr_reg(1'b0, 8'h0C);
      rd_reg(1'b0, d); chk("R7 poll in smm", d, 8'h85);
      tick();
      chk("R7 nothing left", {7'b0, irq_out}, 8'h00);
      wr_reg(1'b0, 8'h48);
      wr_reg(1'b0, 8'h65);
      rd_reg(1'b0, d); chk("R10 specific clears level5", d, 8'h08);
      chk("R7 smm kept without enable", {7'b0, irq_out}, 8'h01);
      wr_reg(1'b0, 8'h28);
      chk("R7 smm left", {7'b0, irq_out}, 8'h00);

      // R8 bit7 set ignored
      wr_reg(1'b0, 8'h8A);
      rd_reg(1'b0, d); chk("R8 select unchanged", d, 8'h08);
      wr_reg(1'b0, 8'h8C);
      rd_reg(1'b0, d); chk("R8 poll not armed", d, 8'h08);

      // R11 lowest index wins
      wr_reg(1'b0, 8'h20);
      irq_req = 8'hFF;
      wr_reg(1'b0, 8'h0C);
      rd_reg(1'b0, d); chk("R11 level0 wins", d, 8'h80);

      // R1 reset with dirty state
      irq_req = 8'h00;
      wr_reg(1'b1, 8'hF0);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      chk("R1 irq low after reset", {7'b0, irq_out}, 8'h00);
      rd_reg(1'b1, d); chk("R1 mask cleared", d, 8'h00);
      irq_req = 8'h11;
      rd_reg(1'b0, d); chk("R1 select back on pending", d, 8'h11);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule